// File: doc/BRIEF.md
# Walker Memory Request Issue Scheduler

This block sits between a page-table walker and a memory port that may refuse a request or return it with a negative acknowledgement (NACK). The walker deposits work into the block. There is a single slot for the next table read, and a small stack of pending write-backs, which are accessed-bit updates. Each cycle the block offers at most one request on a valid/accept handshake. A request that is refused freezes all issue until the port signals that a retry is possible.

Every accepted request increases an outstanding counter, and every response decreases it. A response that carries a NACK is pushed straight back onto the port in the same cycle. If that resend cannot go out, it is parked again, by its type, in the read slot or on the write stack. When nothing is outstanding and nothing is waiting, the block raises a one-cycle pulse telling the walker that its memory traffic is fully drained.

Top module: `wmis_sched`

## Requirements
- R1: When not in retry-wait and no NACK arrives, a pending read is offered (`req_is_wr`=0, `req_data`=0) ahead of any queued write.
- R2: While the retry-wait flag is set, `req_valid` stays 0.
- R3: An offered request with `req_accept`=0 sets retry-wait. A cycle with `retry_ok`=1 clears it, provided no NACK arrives in that same cycle. Offering resumes in the next cycle.
- R4: Queued writes are offered newest first (last in, first out). A write that is accepted leaves the queue. When a NACKed write is re-queued and a new write is pushed in the same cycle, the new write lands on top.
- R5: `outstanding` rises by one for each accepted request and falls by one for each cycle with `rsp_valid`=1. Both take effect at the next edge.
- R6: A response with `rsp_valid`=1 and `rsp_nack`=1, arriving outside retry-wait, is offered in the same cycle with its type, address and data, ahead of the read slot and the queue.
- R7: A NACKed response that is refused, or that arrives during retry-wait, is parked by type: a read goes to the read slot, a write goes on top of the queue. Retry-wait is then set.
- R8: `walk_done` pulses for exactly one cycle, in the first cycle in which `outstanding` is 0, no read is pending and the queue is empty, after a cycle in which that was not the case.
- R9: `wr_ready` is 1 exactly when the queue count plus `outstanding` is below DEPTH (default 4). A `wr_push` while `wr_ready`=0 is ignored.
- R10: A read that would enter an occupied read slot raises `proto_err` in that cycle and is dropped; the slot keeps its old content. This covers a `rd_push`, a parked NACKed read, or both in one cycle. If both arrive together while the slot is free, the parked read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_push | input | 1 | Deposit a read into the read slot |
| rd_addr | input | 16 | Address of the deposited read |
| wr_push | input | 1 | Push a write-back onto the queue |
| wr_addr | input | 16 | Write-back address |
| wr_data | input | 16 | Write-back data |
| wr_ready | output | 1 | Write queue has room (R9) |
| req_valid | output | 1 | A request is offered to the port |
| req_is_wr | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Offered address |
| req_data | output | 16 | Offered data (0 for reads) |
| req_accept | input | 1 | Port takes the offered request |
| retry_ok | input | 1 | Port may be tried again |
| rsp_valid | input | 1 | A response returns this cycle |
| rsp_nack | input | 1 | The response is a negative acknowledgement |
| rsp_is_wr | input | 1 | Type of the returned request |
| rsp_addr | input | 16 | Address of the returned request |
| rsp_data | input | 16 | Data of the returned request |
| outstanding | output | 4 | Requests accepted and not yet answered |
| walk_done | output | 1 | One-cycle drained pulse |
| proto_err | output | 1 | Read deposited into an occupied slot |

## Verification
The hardest situation to reach is a NACKed request that collides with other traffic. One case is a NACKed request that is refused or arrives during retry-wait and must be parked. Another is a parked read that meets a walker read in the same cycle. A third is a parked write that shares a cycle with a fresh write push, which decides the stack order.

The bench remembers every accepted request, so it can return any of them later as a NACK with the exact fields. It uses directed sequences with the port refusing on purpose to force parking, followed by a long stretch of mixed random accept, retry, push and NACK traffic. A behavioural model is compared on every cycle throughout.

// File: rtl/wmis_pkg.sv
package wmis_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mreq_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_NACK  = 2'd1,
        SRC_READ  = 2'd2,
        SRC_WRITE = 2'd3
    } src_e;

    function automatic mreq_t mk_read(input logic [ADDR_W-1:0] a);
        mreq_t r;
        r.is_wr = 1'b0;
        r.addr  = a;
        r.data  = '0;
        return r;
    endfunction

endpackage

// File: rtl/wmis_stack.sv
module wmis_stack
    import wmis_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pop,
    input  logic                          push_a,
    input  mreq_t                         a,
    input  logic                          push_b,
    input  mreq_t                         b,
    output mreq_t                         top,
    output logic [$clog2(DEPTH+1)-1:0]    cnt
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mreq_t          mem [DEPTH];
    logic [CW-1:0]  base;
    logic [CW-1:0]  slot_b;
    logic [CW-1:0]  next_cnt;

    always_comb begin
        base     = cnt - CW'(pop);
        slot_b   = base + CW'(push_a);
        next_cnt = slot_b + CW'(push_b);
        top      = mem[IW'(cnt - CW'(1))];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            if (push_a) mem[IW'(base)]   <= a;
            if (push_b) mem[IW'(slot_b)] <= b;
            cnt <= next_cnt;
        end
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_a || push_b) |-> (int'(next_cnt) <= DEPTH)); // R9

    AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0)); // R4

endmodule

// File: rtl/wmis_arb.sv
module wmis_arb
    import wmis_pkg::*;
(
    input  logic              wait_q,
    input  logic              nack_v,
    input  mreq_t             rsp_req,
    input  logic              rd_v,
    input  logic [ADDR_W-1:0] rd_addr_q,
    input  logic              wq_nonempty,
    input  mreq_t             wq_top,
    output logic              req_v,
    output mreq_t             req,
    output src_e              src
);
    always_comb begin
        req_v = 1'b0;
        req   = '0;
        src   = SRC_NONE;
        if (!wait_q) begin
            if (nack_v) begin
                req_v = 1'b1;
                req   = rsp_req;
                src   = SRC_NACK;
            end else if (rd_v) begin
                req_v = 1'b1;
                req   = mk_read(rd_addr_q);
                src   = SRC_READ;
            end else if (wq_nonempty) begin
                req_v = 1'b1;
                req   = wq_top;
                src   = SRC_WRITE;
            end
        end
    end

endmodule

// File: rtl/wmis_track.sv
module wmis_track #(
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             rsp_v,
    input  logic             idle_q,
    output logic [OUT_W-1:0] outst,
    output logic             done
);
    logic busy_q;
    logic complete;

    always_comb begin
        complete = (outst == '0) && idle_q;
        done     = complete && busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outst  <= '0;
            busy_q <= 1'b0;
        end else begin
            outst  <= outst + OUT_W'(acc) - OUT_W'(rsp_v);
            busy_q <= !complete;
        end
    end

    AST_OUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc && !rsp_v) |=> (outst == $past(outst) + OUT_W'(1))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

endmodule

// File: rtl/wmis_sched.sv
module wmis_sched
    import wmis_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OUT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_push,
    input  logic [15:0]       rd_addr,
    input  logic              wr_push,
    input  logic [15:0]       wr_addr,
    input  logic [15:0]       wr_data,
    output logic              wr_ready,
    output logic              req_valid,
    output logic              req_is_wr,
    output logic [15:0]       req_addr,
    output logic [15:0]       req_data,
    input  logic              req_accept,
    input  logic              retry_ok,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic              rsp_is_wr,
    input  logic [15:0]       rsp_addr,
    input  logic [15:0]       rsp_data,
    output logic [OUT_W-1:0]  outstanding,
    output logic              walk_done,
    output logic              proto_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              wait_q;
    logic              rd_v;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [CW-1:0]     wq_cnt;
    mreq_t             wq_top;
    mreq_t             rsp_req;
    mreq_t             wr_req;
    mreq_t             req;
    src_e              src;
    logic              nack_v;
    logic              acc;
    logic              requeue;
    logic              rq_rd;
    logic              rq_wr;
    logic              push_b;
    logic              pop;

    always_comb begin
        nack_v        = rsp_valid && rsp_nack;
        rsp_req.is_wr = rsp_is_wr;
        rsp_req.addr  = rsp_addr;
        rsp_req.data  = rsp_is_wr ? rsp_data : '0;
        wr_req.is_wr  = 1'b1;
        wr_req.addr   = wr_addr;
        wr_req.data   = wr_data;
    end

    wmis_arb u_arb (
        .wait_q      (wait_q),
        .nack_v      (nack_v),
        .rsp_req     (rsp_req),
        .rd_v        (rd_v),
        .rd_addr_q   (rd_addr_q),
        .wq_nonempty (wq_cnt != '0),
        .wq_top      (wq_top),
        .req_v       (req_valid),
        .req         (req),
        .src         (src)
    );

    always_comb begin
        req_is_wr = req.is_wr;
        req_addr  = req.addr;
        req_data  = req.data;
        acc       = req_valid && req_accept;
        requeue   = nack_v && (wait_q || !req_accept);
        rq_rd     = requeue && !rsp_is_wr;
        rq_wr     = requeue && rsp_is_wr;
        pop       = acc && (src == SRC_WRITE);
        wr_ready  = (int'(wq_cnt) + int'(outstanding)) < DEPTH;
        push_b    = wr_push && wr_ready;
        proto_err = (rd_push && (rd_v || rq_rd)) || (rq_rd && rd_v);
    end

    // retry-wait flag
    always_ff @(posedge clk) begin
        if (rst) wait_q <= 1'b0;
        else     wait_q <= (wait_q && !retry_ok) || (req_valid && !req_accept) || requeue;
    end

    // single read slot: parked NACKed read has precedence over a new deposit
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v      <= 1'b0;
            rd_addr_q <= '0;
        end else if (!rd_v) begin
            if (rq_rd) begin
                rd_v      <= 1'b1;
                rd_addr_q <= rsp_addr;
            end else if (rd_push) begin
                rd_v      <= 1'b1;
                rd_addr_q <= rd_addr;
            end
        end else if (acc && (src == SRC_READ)) begin
            rd_v <= 1'b0;
        end
    end

    wmis_stack #(.DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .pop    (pop),
        .push_a (rq_wr),
        .a      (rsp_req),
        .push_b (push_b),
        .b      (wr_req),
        .top    (wq_top),
        .cnt    (wq_cnt)
    );

    wmis_track #(.OUT_W(OUT_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .rsp_v  (rsp_valid),
        .idle_q (!rd_v && (wq_cnt == '0)),
        .outst  (outstanding),
        .done   (walk_done)
    );

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rd_v && !nack_v && !wait_q) |-> (req_valid && !req_is_wr && req_addr == rd_addr_q)); // R1

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> !req_valid); // R2

    AST_REFUSE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_accept) |=> wait_q); // R3

    AST_RETRY_RESUME: assert property (@(posedge clk) disable iff (rst)
        (wait_q && retry_ok && !nack_v) |=> !wait_q); // R3

    AST_NACK_ECHO: assert property (@(posedge clk) disable iff (rst)
        (nack_v && !wait_q) |-> (req_valid && req_is_wr == rsp_is_wr && req_addr == rsp_addr)); // R6

    AST_PARK_WAIT: assert property (@(posedge clk) disable iff (rst)
        requeue |=> wait_q); // R7

endmodule

// File: tb/wmis_sched_tb.sv
`timescale 1ns/1ps
module wmis_sched_tb;
    localparam int DEPTH = 4;
    localparam int OUT_W = 4;

    logic clk = 1'b0;
    logic rst;
    logic rd_push, wr_push, req_accept, retry_ok, rsp_valid, rsp_nack, rsp_is_wr;
    logic [15:0] rd_addr, wr_addr, wr_data, rsp_addr, rsp_data;
    logic wr_ready, req_valid, req_is_wr, walk_done, proto_err;
    logic [15:0] req_addr, req_data;
    logic [OUT_W-1:0] outstanding;

    always #2.5 clk = ~clk;

    wmis_sched #(.DEPTH(DEPTH), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst(rst),
        .rd_push(rd_push), .rd_addr(rd_addr),
        .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .req_valid(req_valid), .req_is_wr(req_is_wr), .req_addr(req_addr), .req_data(req_data),
        .req_accept(req_accept), .retry_ok(retry_ok),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_is_wr(rsp_is_wr),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .outstanding(outstanding), .walk_done(walk_done), .proto_err(proto_err)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit          m_rd_v;
    logic [15:0] m_rd_addr;
    logic [15:0] q_a[$];
    logic [15:0] q_d[$];
    bit          m_wait;
    int          m_out;
    bit          m_busy;
    // requests in flight at the port
    bit          f_w[$];
    logic [15:0] f_a[$];
    logic [15:0] f_d[$];

    // per-cycle expectations
    bit          e_v, e_w, e_ready, e_complete, e_requeue, e_rqr;
    logic [15:0] e_a, e_d;
    int          e_src; // 0 none 1 nack 2 read 3 write

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_idle();
        rd_push = 0; rd_addr = 0; wr_push = 0; wr_addr = 0; wr_data = 0;
        req_accept = 1; retry_ok = 0; rsp_valid = 0; rsp_nack = 0;
        rsp_is_wr = 0; rsp_addr = 0; rsp_data = 0;
    endtask

    task automatic eval();
        string tag;
        bit nack;
        bit perr;
        #1;
        nack = rsp_valid && rsp_nack;
        e_w = 0; e_a = 0; e_d = 0;
        if (m_wait) begin
            e_v = 0; e_src = 0; tag = "R2 R3 req_valid";
        end else if (nack) begin
            e_v = 1; e_src = 1; e_w = rsp_is_wr; e_a = rsp_addr;
            e_d = rsp_is_wr ? rsp_data : 16'h0; tag = "R6 nack resend";
        end else if (m_rd_v) begin
            e_v = 1; e_src = 2; e_a = m_rd_addr; tag = "R1 read first";
        end else if (q_a.size() > 0) begin
            e_v = 1; e_src = 3; e_w = 1; e_a = q_a[$]; e_d = q_d[$]; tag = "R4 newest write";
        end else begin
            e_v = 0; e_src = 0; tag = "R2 idle";
        end
        chk({tag, " valid"}, req_valid, e_v);
        if (e_v) begin
            chk({tag, " is_wr"}, req_is_wr, e_w);
            chk({tag, " addr"}, req_addr, e_a);
            chk({tag, " data"}, req_data, e_d);
        end
        e_ready    = (q_a.size() + m_out) < DEPTH;
        e_complete = (m_out == 0) && !m_rd_v && (q_a.size() == 0);
        e_requeue  = nack && (m_wait || !req_accept);
        e_rqr      = e_requeue && !rsp_is_wr;
        perr       = (rd_push && (m_rd_v || e_rqr)) || (e_rqr && m_rd_v);
        chk("R9 wr_ready", wr_ready, e_ready);
        chk("R5 outstanding", outstanding, m_out);
        chk("R8 walk_done", walk_done, e_complete && m_busy);
        chk("R10 proto_err", proto_err, perr);
    endtask

    task automatic adv();
        bit acc;
        @(posedge clk);
        acc = e_v && req_accept;
        if (rsp_valid) begin
            for (int i = 0; i < f_a.size(); i++) begin
                if (f_w[i] == rsp_is_wr && f_a[i] == rsp_addr && f_d[i] == (rsp_is_wr ? rsp_data : 16'h0)) begin
                    f_w.delete(i); f_a.delete(i); f_d.delete(i);
                    break;
                end
            end
        end
        if (acc) begin
            f_w.push_back(e_w); f_a.push_back(e_a); f_d.push_back(e_d);
        end
        m_out = m_out + (acc ? 1 : 0) - (rsp_valid ? 1 : 0);
        if (!m_rd_v) begin
            if (e_rqr) begin m_rd_v = 1; m_rd_addr = rsp_addr; end
            else if (rd_push) begin m_rd_v = 1; m_rd_addr = rd_addr; end
        end else if (acc && e_src == 2) begin
            m_rd_v = 0;
        end
        if (acc && e_src == 3) begin
            void'(q_a.pop_back()); void'(q_d.pop_back());
        end
        if (e_requeue && rsp_is_wr) begin
            q_a.push_back(rsp_addr); q_d.push_back(rsp_data);
        end
        if (wr_push && e_ready) begin
            q_a.push_back(wr_addr); q_d.push_back(wr_data);
        end
        m_wait = (m_wait && !retry_ok) || (e_v && !req_accept) || e_requeue;
        m_busy = !e_complete;
        @(negedge clk);
        set_idle();
    endtask

    task automatic cyc();
        eval();
        adv();
    endtask

    task automatic give_rsp(input int idx, input bit nack);
        rsp_valid = 1; rsp_nack = nack;
        rsp_is_wr = f_w[idx]; rsp_addr = f_a[idx]; rsp_data = f_d[idx];
    endtask

    task automatic drain();
        for (int n = 0; n < 200; n++) begin
            retry_ok = 1;
            if (f_a.size() > 0) give_rsp(0, 0);
            cyc();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        set_idle();
        rst = 1;
        m_rd_v = 0; m_rd_addr = 0; m_wait = 0; m_out = 0; m_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        set_idle();

        // reset state (R2, R5, R8, R9 checked by the model compare)
        cyc();

        // LIFO drain after a refusal / retry
        req_accept = 0; wr_push = 1; wr_addr = 16'h0010; wr_data = 16'h0011; cyc();
        req_accept = 0; wr_push = 1; wr_addr = 16'h0020; wr_data = 16'h0021; cyc();
        wr_push = 1; wr_addr = 16'h0030; wr_data = 16'h0031; cyc();
        eval(); chk("R3 silent while waiting", req_valid, 0); adv();
        retry_ok = 1; cyc();
        eval(); chk("R4 newest first addr", req_addr, 16'h0030); adv();
        eval(); chk("R4 second addr", req_addr, 16'h0020); adv();
        eval(); chk("R4 oldest addr", req_addr, 16'h0010); adv();
        for (int k = 0; k < 3; k++) begin give_rsp(0, 0); cyc(); end
        eval(); chk("R8 drained pulse", walk_done, 1); adv();
        eval(); chk("R8 pulse ends", walk_done, 0); adv();

        // read priority over write
        wr_push = 1; wr_addr = 16'h0130; wr_data = 16'h0A0A;
        rd_push = 1; rd_addr = 16'h0140; cyc();
        eval(); chk("R1 read before write", req_is_wr, 0); adv();
        cyc();

        // NACKs that are refused or arrive during retry-wait get parked
        req_accept = 0;
        for (int i = 0; i < f_a.size(); i++) if (f_w[i]) begin give_rsp(i, 1); break; end
        cyc();
        for (int i = 0; i < f_a.size(); i++) if (!f_w[i]) begin give_rsp(i, 1); break; end
        cyc();
        retry_ok = 1; cyc();
        eval(); chk("R7 parked read addr", req_addr, 16'h0140);
        chk("R7 parked read kind", req_is_wr, 0); adv();
        eval(); chk("R7 parked write addr", req_addr, 16'h0130);
        chk("R7 parked write data", req_data, 16'h0A0A); adv();
        drain();

        // read into an occupied slot
        req_accept = 0; rd_push = 1; rd_addr = 16'h0050; cyc();
        req_accept = 0; rd_push = 1; rd_addr = 16'h0060;
        eval(); chk("R10 second read flagged", proto_err, 1); adv();
        retry_ok = 1; cyc();
        eval(); chk("R10 old read kept", req_addr, 16'h0050); adv();
        drain();

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            req_accept = ($urandom % 10) < 7;
            retry_ok   = ($urandom % 4) == 0;
            rd_push    = (($urandom % 6) == 0) && (m_out < 9);
            rd_addr    = 16'($urandom);
            wr_push    = ($urandom % 3) == 0;
            wr_addr    = 16'($urandom);
            wr_data    = 16'($urandom);
            if (f_a.size() > 0 && ($urandom % 3) == 0)
                give_rsp(int'($urandom % f_a.size()), ($urandom % 4) == 0);
            cyc();
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule